// File: doc/BRIEF.md
# SMM Memory Window Access Controller

This block holds the host bridge's control byte for the 128 KB legacy system-management RAM window that spans 0xA0000 to 0xBFFFF. It decides, for every address on its address input, whether the access is steered to DRAM or left to the PCI/video side. Two conditions open the window: a software-controlled open bit, and the CPU reporting that it is in system-management mode. A global enable must be set for either condition to take effect. A close bit overrides the open bit. A lock bit freezes the configuration until the next reset.

Software reaches the byte through a one-byte configuration port at offset 0x9D. The route output is combinational in the address, the SMM indication and the stored register bits. It therefore follows a change of the SMM input at once and follows a register write from the clock edge that stores it.

Top module: `smram_window_ctrl`

## Requirements
- R1: After reset the control byte at configuration offset 0x9D reads 0x02. With that value every access routes to PCI, and route_dram is 0 even while smm_active is 1.
- R2: The byte layout is open = bit 6, close = bit 5, lock = bit 4, global enable = bit 3, base segment = bits 2:0. The base segment always reads 3'b010, and bit 7 always reads 0, whatever value is written.
- R3: A write to any offset other than 0x9D changes nothing. A read of any other offset returns 0x00.
- R4: route_dram is 0 for every address outside the range from 0xA0000 up to but not including 0xC0000 (window size 0x20000).
- R5: Inside the window, route_dram is 1 when global enable is 1, open is 1 and close is 0.
- R6: Inside the window, route_dram is 1 when global enable is 1 and smm_active is 1, whatever the open and close bits hold.
- R7: When global enable is 0, route_dram is 0 whatever the open bit and smm_active hold.
- R8: When open and close are both 1, accesses without SMM route to PCI, and accesses with SMM still route to DRAM.
- R9: A write that sets lock (bit 4) to 1 stores open as 0 in the same write, even if bit 6 of that write is 1.
- R10: While lock is 1, writes leave lock, open and global enable unchanged, and the close bit remains writable.
- R11: route_dram follows a change of smm_active combinationally, with no clock edge in between.
- R12: Reset clears the lock, after which the byte is writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| smm_active | input | 1 | CPU is in system-management mode |
| mem_addr | input | 32 | Physical address of the current access |
| route_dram | output | 1 | 1 = steer to DRAM, 0 = steer to PCI/video |

## Verification
The bench builds the block with its default parameters: a 32-bit address, the window at 0xA0000 of size 0x20000, and the register at offset 0x9D. These values put the window's edges within reach of the bench: the first and last bytes of the window and the bytes one below and one above it. A table walks the combinations of enable, open, close and SMM at those addresses. Directed steps then cover the lock sequence, an SMM change between clock edges, and a second reset that releases the lock.

// File: rtl/smram_window_ctrl.sv
module smram_window_ctrl #(
  parameter int          ADDR_W   = 32,
  parameter logic [7:0]  REG_OFF  = 8'h9D,
  parameter logic [63:0] WIN_BASE = 64'h000A_0000,
  parameter logic [63:0] WIN_SIZE = 64'h0002_0000,
  parameter logic [2:0]  SEG_VAL  = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smm_active,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              route_dram
);

  localparam logic [63:0] WIN_END = WIN_BASE + WIN_SIZE;
  localparam int B_OPEN  = 6;
  localparam int B_CLOSE = 5;
  localparam int B_LOCK  = 4;
  localparam int B_EN    = 3;

  logic open_q, close_q, lock_q, en_q;
  logic hit, in_win, win_open;
  logic [63:0] addr_ext;

  assign hit      = (cfg_addr == REG_OFF);
  assign addr_ext = 64'(mem_addr);
  assign in_win   = (addr_ext >= WIN_BASE) && (addr_ext < WIN_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      close_q <= 1'b0;
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
    end else if (cfg_we && hit) begin
      close_q <= cfg_wdata[B_CLOSE];
      if (!lock_q) begin
        lock_q <= cfg_wdata[B_LOCK];
        en_q   <= cfg_wdata[B_EN];
        open_q <= cfg_wdata[B_OPEN] & ~cfg_wdata[B_LOCK];
      end
    end
  end

  assign cfg_rdata  = hit ? {1'b0, open_q, close_q, lock_q, en_q, SEG_VAL} : 8'h00;
  assign win_open   = (open_q & ~close_q) | smm_active;
  assign route_dram = in_win & en_q & win_open;

  a_r9_lock_clears_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && hit && cfg_wdata[B_LOCK] && !lock_q) |=> (lock_q && !open_q));

  a_r10_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(en_q) && !open_q));

  a_r7_disabled_to_pci: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[B_EN] && hit |-> !route_dram);

  a_r6_smm_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_active && in_win && en_q) |-> route_dram);

  a_r4_outside_pci: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> !route_dram);

endmodule

// File: tb/tb_smram_window_ctrl.sv
module tb_smram_window_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h9D;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic smm_active = 1'b0;
  logic [31:0] mem_addr = 32'h0;
  logic route_dram;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smram_window_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_active(smm_active),
    .mem_addr(mem_addr), .route_dram(route_dram)
  );

  // {wdata, smm, addr, exp_route, exp_rdata}
  localparam int NV = 13;
  localparam logic [49:0] VEC [NV] = '{
    {8'h48, 1'b0, 32'h000A_0000, 1'b1, 8'h4A},  // R5
    {8'h48, 1'b0, 32'h000B_FFFF, 1'b1, 8'h4A},  // R5 last byte
    {8'h48, 1'b0, 32'h000C_0000, 1'b0, 8'h4A},  // R4 above
    {8'h48, 1'b0, 32'h0009_FFFF, 1'b0, 8'h4A},  // R4 below
    {8'h40, 1'b0, 32'h000A_0000, 1'b0, 8'h42},  // R7
    {8'h40, 1'b1, 32'h000A_0000, 1'b0, 8'h42},  // R7 with smm
    {8'h08, 1'b0, 32'h000B_0000, 1'b0, 8'h0A},  // R6 baseline
    {8'h08, 1'b1, 32'h000B_0000, 1'b1, 8'h0A},  // R6
    {8'h68, 1'b0, 32'h000A_8000, 1'b0, 8'h6A},  // R8
    {8'h68, 1'b1, 32'h000A_8000, 1'b1, 8'h6A},  // R8 smm
    {8'h28, 1'b1, 32'h000A_0000, 1'b1, 8'h2A},  // R6 close set
    {8'h8F, 1'b0, 32'h000A_0000, 1'b0, 8'h0A},  // R2
    {8'h00, 1'b1, 32'h000C_0000, 1'b0, 8'h02}   // R4 / R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 8'h9D;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    do_reset();
    smm_active = 1'b1; mem_addr = 32'h000A_0000; #1;
    check("R1 rdata", 32'(cfg_rdata), 32'h02);
    check("R1 route", 32'(route_dram), 32'h0);
    smm_active = 1'b0;

    wr(8'h9C, 8'h48);
    check("R3 main unchanged", 32'(cfg_rdata), 32'h02);
    cfg_addr = 8'h9C; #1;
    check("R3 other reads zero", 32'(cfg_rdata), 32'h00);
    cfg_addr = 8'h9D; #1;

    for (int i = 0; i < NV; i++) begin
      wr(8'h9D, VEC[i][49:42]);
      smm_active = VEC[i][41];
      mem_addr = VEC[i][40:9];
      #1;
      check("table route", 32'(route_dram), 32'(VEC[i][8]));
      check("table rdata", 32'(cfg_rdata), 32'(VEC[i][7:0]));
      smm_active = 1'b0;
    end

    wr(8'h9D, 8'h08);
    mem_addr = 32'h000A_4000;
    @(negedge clk); #2;
    smm_active = 1'b1; #1;
    check("R11 rise", 32'(route_dram), 32'h1);
    smm_active = 1'b0; #1;
    check("R11 fall", 32'(route_dram), 32'h0);

    wr(8'h9D, 8'h58);
    check("R9 lock clears open", 32'(cfg_rdata), 32'h1A);
    check("R9 route", 32'(route_dram), 32'h0);
    wr(8'h9D, 8'h40);
    check("R10 frozen", 32'(cfg_rdata), 32'h1A);
    wr(8'h9D, 8'h20);
    check("R10 close writable", 32'(cfg_rdata), 32'h3A);
    wr(8'h9D, 8'h00);
    check("R10 close cleared", 32'(cfg_rdata), 32'h1A);
    smm_active = 1'b1; #1;
    check("R10 enable kept", 32'(route_dram), 32'h1);
    smm_active = 1'b0;

    do_reset();
    check("R12 reset value", 32'(cfg_rdata), 32'h02);
    wr(8'h9D, 8'h48);
    check("R12 writable", 32'(cfg_rdata), 32'h4A);
    check("R12 route", 32'(route_dram), 32'h1);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule